// File: doc/BRIEF.md
# Configurable Multiply-Add Datapath

This block is a two-stage integer multiply-accumulate unit. It takes three 32-bit source words. Two of them are multiplicands, and each multiplicand can be read as a signed or unsigned byte, halfword or full word. For narrow formats, a lane index picks which byte or halfword is used. The selected lanes are widened and multiplied. The third word is added, subtracted, or has the product subtracted from it, and a plus-one mode supports rounded averages. The intermediate value is wide enough that nothing is lost.

The exact sum then passes through a right shift of 0, 7 or 15 bits. The shift fills with the sign bit when the result is signed and with zeros when it is unsigned. The shifted value is either clamped to the 32-bit range of its signedness or cut to its low 32 bits. Negation requests on the operands are folded into a single internal add-mode code. Option combinations that cannot be honoured raise an error flag and give a zero result.

Top module: `mad_unit`

## Requirements
- R1: A format is 3 bits: bit 2 means signed, and bits 1:0 give the width (0 byte, 1 halfword, 2 word, 3 reserved). A byte lane is selected by the 2-bit lane index (byte k is bits 8k+7:8k). A halfword is selected by bit 0 of the lane index. A full word ignores the lane index. The selected lane is sign- or zero-extended according to bit 2.
- R2: The computation is unsigned only when both formats are unsigned, neg_c is clear and neg_a equals neg_b. Otherwise it is signed, and the addend is then sign-extended from bit 31.
- R3: With no negation and plus_one clear, the exact value is A*B+C. With plus_one set, it is A*B+C+1.
- R4: neg_c alone gives A*B-C. Exactly one of neg_a and neg_b gives C-A*B. Setting both neg_a and neg_b gives the same result as setting neither.
- R5: The options are illegal if any of these holds: neg_c together with exactly one of neg_a or neg_b; plus_one together with any negation; scale code 3; or a reserved width. An illegal vector gives err=1 and result=0.
- R6: Scale code 0 leaves the value unshifted, code 1 shifts it right by 7 and code 2 shifts it right by 15. The shift is arithmetic when the computation is signed and logical otherwise.
- R7: With saturate set, a signed value is clamped to the range 0x80000000 to 0x7FFFFFFF. An unsigned value is clamped to the range 0 to 0xFFFFFFFF.
- R8: With saturate clear, the result is the low 32 bits of the shifted value.
- R9: A vector accepted with in_valid appears with out_valid two clock edges later. The unit accepts a new vector on every cycle.
- R10: While rst_n is low, out_valid, err and result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input vector valid |
| opa | input | 32 | Multiplicand A source word |
| opb | input | 32 | Multiplicand B source word |
| opc | input | 32 | Addend word |
| fmt_a | input | 3 | Format of A: {signed, width} |
| fmt_b | input | 3 | Format of B: {signed, width} |
| lane_a | input | 2 | Lane index for A |
| lane_b | input | 2 | Lane index for B |
| neg_a | input | 1 | Negate A request |
| neg_b | input | 1 | Negate B request |
| neg_c | input | 1 | Negate addend request |
| plus_one | input | 1 | Add one (rounding) |
| scale | input | 2 | Right-shift selector |
| saturate | input | 1 | Clamp enable |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Result word |
| err | output | 1 | Illegal option combination |

## Verification
The error override and the clamp can both apply to the same vector. The sweep provokes this by pairing illegal negation or scale codes with saturate set and with extreme operands whose sum would clamp, and the error override must win with a zero result. Shifting and clamping also meet in one output cycle: vectors whose values sit near the 32-bit boundary are run with scales 7 and 15 under saturation. Each output is judged against a reference model in the bench that uses wide signed integers.

// File: rtl/mad_pkg.sv
package mad_pkg;

  typedef enum logic [1:0] {
    LW_BYTE = 2'd0,
    LW_HALF = 2'd1,
    LW_WORD = 2'd2,
    LW_RSVD = 2'd3
  } lane_width_e;

  typedef struct packed {
    logic        is_signed;
    lane_width_e width;
  } opfmt_t;

  // Selects the whole add expression applied to product P and addend C
  typedef enum logic [1:0] {
    AM_ADD  = 2'd0,  // P + C
    AM_SUBC = 2'd1,  // P + ~C + 1
    AM_NEGP = 2'd2,  // ~P + C + 1
    AM_INC  = 2'd3   // P + C + 1
  } add_mode_e;

  typedef enum logic [1:0] {
    SC_NONE = 2'd0,
    SC_SH7  = 2'd1,
    SC_SH15 = 2'd2,
    SC_BAD  = 2'd3
  } scale_e;

  function automatic add_mode_e pick_mode(input logic na, input logic nb,
                                          input logic nc, input logic inc);
    if (inc)          return AM_INC;
    else if (nc)      return AM_SUBC;
    else if (na ^ nb) return AM_NEGP;
    else              return AM_ADD;
  endfunction

  function automatic logic opts_illegal(input logic na, input logic nb,
                                        input logic nc, input logic inc);
    return (nc & (na ^ nb)) | (inc & (na | nb | nc));
  endfunction

endpackage

// File: rtl/mad_lane_sel.sv
module mad_lane_sel
  import mad_pkg::*;
#(
  parameter int DW  = 32,
  parameter int LSW = $clog2(DW / 8)
) (
  input  logic [DW-1:0]  word,
  input  opfmt_t         fmt,
  input  logic [LSW-1:0] lane,
  output logic [DW-1:0]  ext,
  output logic           fmt_bad
);
  localparam int NB = DW / 8;
  localparam int NH = DW / 16;

  logic [7:0]  bytes_v [NB];
  logic [15:0] halves_v[NH];

  for (genvar g = 0; g < NB; g++) begin : g_bytes
    assign bytes_v[g] = word[8*g +: 8];
  end
  for (genvar g = 0; g < NH; g++) begin : g_halves
    assign halves_v[g] = word[16*g +: 16];
  end

  logic [7:0]  byte_sel;
  logic [15:0] half_sel;

  always_comb begin
    byte_sel = bytes_v[lane];
    half_sel = halves_v[lane[LSW-2:0]];
    fmt_bad  = 1'b0;
    unique case (fmt.width)
      LW_BYTE: ext = {{(DW-8){fmt.is_signed & byte_sel[7]}}, byte_sel};
      LW_HALF: ext = {{(DW-16){fmt.is_signed & half_sel[15]}}, half_sel};
      LW_WORD: ext = word;
      default: begin
        ext     = '0;
        fmt_bad = 1'b1;
      end
    endcase
  end

  always_comb begin
    if (fmt.width == LW_BYTE && !fmt.is_signed)
      AST_LANE_ZEXT: assert (ext[DW-1:8] == '0); // R1
  end

endmodule

// File: rtl/mad_accum.sv
module mad_accum
  import mad_pkg::*;
#(
  parameter int DW = 32,
  parameter int TW = 2 * DW + 3
) (
  input  logic [DW-1:0] a_ext,
  input  logic          a_sgn,
  input  logic [DW-1:0] b_ext,
  input  logic          b_sgn,
  input  logic [DW-1:0] c_word,
  input  add_mode_e     mode,
  output logic          prod_signed,
  output logic [TW-1:0] tmp
);
  localparam int PW = 2 * DW + 2;

  function automatic logic [TW-1:0] mac(input logic [DW-1:0] a, input logic as,
                                        input logic [DW-1:0] b, input logic bs,
                                        input logic [DW-1:0] c, input logic cs,
                                        input add_mode_e m);
    logic signed [DW:0]   ma, mb;
    logic signed [PW-1:0] p;
    logic [TW-1:0]        pw, cw;
    ma = {as & a[DW-1], a};
    mb = {bs & b[DW-1], b};
    p  = ma * mb;
    pw = {{(TW-PW){p[PW-1]}}, p};
    cw = {{(TW-DW){cs & c[DW-1]}}, c};
    return ((m == AM_NEGP) ? ~pw : pw) + ((m == AM_SUBC) ? ~cw : cw)
           + TW'(m != AM_ADD);
  endfunction

  assign prod_signed = a_sgn | b_sgn | (mode == AM_SUBC) | (mode == AM_NEGP);
  assign tmp = mac(a_ext, a_sgn, b_ext, b_sgn, c_word, prod_signed, mode);

endmodule

// File: rtl/mad_normsat.sv
module mad_normsat
  import mad_pkg::*;
#(
  parameter int DW      = 32,
  parameter int TW      = 2 * DW + 3,
  parameter int SHIFT_A = 7,
  parameter int SHIFT_B = 15
) (
  input  logic [TW-1:0] tmp,
  input  logic          res_signed,
  input  scale_e        scale,
  input  logic          sat,
  output logic [DW-1:0] res,
  output logic          clamp_hi,
  output logic          clamp_lo
);
  function automatic logic [TW-1:0] rshift(input logic [TW-1:0] v,
                                           input logic fill, input int k);
    return (v >> k) | (fill ? ~({TW{1'b1}} >> k) : '0);
  endfunction

  logic [TW-1:0] shr;
  logic          fill, sgn_fits;

  always_comb begin
    fill = res_signed & tmp[TW-1];
    unique case (scale)
      SC_SH7:  shr = rshift(tmp, fill, SHIFT_A);
      SC_SH15: shr = rshift(tmp, fill, SHIFT_B);
      default: shr = tmp;
    endcase
    sgn_fits = (&shr[TW-1:DW-1]) | ~(|shr[TW-1:DW-1]);
    if (res_signed) begin
      clamp_hi = !sgn_fits && !shr[TW-1];
      clamp_lo = !sgn_fits &&  shr[TW-1];
    end else begin
      clamp_hi = !shr[TW-1] && (|shr[TW-1:DW]);
      clamp_lo = shr[TW-1];
    end
    if (sat && clamp_hi)
      res = res_signed ? {1'b0, {(DW-1){1'b1}}} : {DW{1'b1}};
    else if (sat && clamp_lo)
      res = res_signed ? {1'b1, {(DW-1){1'b0}}} : '0;
    else
      res = shr[DW-1:0];
  end

  always_comb begin
    AST_CLAMP_EXCL: assert ($onehot0({clamp_hi, clamp_lo})); // R7
  end

endmodule

// File: rtl/mad_unit.sv
module mad_unit
  import mad_pkg::*;
#(
  parameter int DW      = 32,
  parameter int LSW     = $clog2(DW / 8),
  parameter int SHIFT_A = 7,
  parameter int SHIFT_B = 15
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [DW-1:0]  opa,
  input  logic [DW-1:0]  opb,
  input  logic [DW-1:0]  opc,
  input  logic [2:0]     fmt_a,
  input  logic [2:0]     fmt_b,
  input  logic [LSW-1:0] lane_a,
  input  logic [LSW-1:0] lane_b,
  input  logic           neg_a,
  input  logic           neg_b,
  input  logic           neg_c,
  input  logic           plus_one,
  input  logic [1:0]     scale,
  input  logic           saturate,
  output logic           out_valid,
  output logic [DW-1:0]  result,
  output logic           err
);
  localparam int TW = 2 * DW + 3;

  opfmt_t        fa, fb;
  logic [DW-1:0] a_ext, b_ext;
  logic          fa_bad, fb_bad;
  add_mode_e     mode;
  logic          illegal_opts;
  logic          prod_signed;
  logic [TW-1:0] tmp;

  assign fa = opfmt_t'(fmt_a);
  assign fb = opfmt_t'(fmt_b);

  mad_lane_sel #(.DW(DW), .LSW(LSW)) u_sel_a (
    .word(opa), .fmt(fa), .lane(lane_a), .ext(a_ext), .fmt_bad(fa_bad));
  mad_lane_sel #(.DW(DW), .LSW(LSW)) u_sel_b (
    .word(opb), .fmt(fb), .lane(lane_b), .ext(b_ext), .fmt_bad(fb_bad));

  assign mode = pick_mode(neg_a, neg_b, neg_c, plus_one);
  assign illegal_opts = opts_illegal(neg_a, neg_b, neg_c, plus_one)
                      | (scale_e'(scale) == SC_BAD) | fa_bad | fb_bad;

  mad_accum #(.DW(DW), .TW(TW)) u_acc (
    .a_ext(a_ext), .a_sgn(fa.is_signed), .b_ext(b_ext), .b_sgn(fb.is_signed),
    .c_word(opc), .mode(mode), .prod_signed(prod_signed), .tmp(tmp));

  // Stage 1: multiply-add
  logic          s1_valid, s1_signed, s1_sat, s1_err;
  logic [TW-1:0] s1_tmp;
  scale_e        s1_scale;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_tmp    <= '0;
      s1_signed <= 1'b0;
      s1_scale  <= SC_NONE;
      s1_sat    <= 1'b0;
      s1_err    <= 1'b0;
    end else begin
      s1_valid  <= in_valid;
      s1_tmp    <= tmp;
      s1_signed <= prod_signed;
      s1_scale  <= scale_e'(scale);
      s1_sat    <= saturate;
      s1_err    <= illegal_opts;
    end
  end

  logic [DW-1:0] ns_res;
  logic          clamp_hi, clamp_lo;

  mad_normsat #(.DW(DW), .TW(TW), .SHIFT_A(SHIFT_A), .SHIFT_B(SHIFT_B)) u_ns (
    .tmp(s1_tmp), .res_signed(s1_signed), .scale(s1_scale), .sat(s1_sat),
    .res(ns_res), .clamp_hi(clamp_hi), .clamp_lo(clamp_lo));

  // Stage 2: shift and saturate
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      err       <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      result    <= s1_err ? '0 : ns_res;
      err       <= s1_err;
    end
  end

  AST_STAGE1_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid); // R9
  AST_STAGE2_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid); // R9
  AST_ERR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && s1_err |=> err && result == '0); // R5
  AST_UNSIGNED_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && !s1_signed && !s1_err |-> !s1_tmp[TW-1]); // R2
  AST_SCALE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && !s1_err |-> s1_scale != SC_BAD); // R6

endmodule

// File: tb/mad_unit_test.sv
module mad_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] opa = '0, opb = '0, opc = '0;
  logic [2:0]  fmt_a = '0, fmt_b = '0;
  logic [1:0]  lane_a = '0, lane_b = '0, scale = '0;
  logic        neg_a = 0, neg_b = 0, neg_c = 0, plus_one = 0, saturate = 0;
  logic        out_valid, err;
  logic [31:0] result;
  int n_vec = 0, n_bad = 0;

  always #2 clk = ~clk;

  mad_unit uut (.*);

  task automatic check(input string tag, input logic [33:0] got, input logic [33:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic signed [127:0] field(input logic [31:0] w,
      input logic [2:0] f, input logic [1:0] l);
    int bits, idx;
    logic signed [127:0] v;
    bits = (f[1:0] == 2'd0) ? 8 : (f[1:0] == 2'd1) ? 16 : 32;
    idx  = (bits == 8) ? int'(l) : (bits == 16) ? int'(l[0]) : 0;
    v = 128'(w >> (idx * bits)) & ((128'sd1 <<< bits) - 1);
    if (f[2] && v[bits-1]) v = v - (128'sd1 <<< bits);
    return v;
  endfunction

  // returns {out_valid, err, result}
  function automatic logic [33:0] model(input logic [31:0] a, b, c,
      input logic [2:0] fa, fb, input logic [1:0] la, lb,
      input logic na, nb, nc, po, input logic [1:0] sc, input logic st);
    logic signed [127:0] pa, pb, pc, t, hi, lo;
    logic sg;
    if (fa[1:0] == 2'd3 || fb[1:0] == 2'd3 || sc == 2'd3 ||
        (nc && (na ^ nb)) || (po && (na || nb || nc)))
      return {2'b11, 32'h0};
    pa = field(a, fa, la);
    pb = field(b, fb, lb);
    sg = fa[2] | fb[2] | nc | (na ^ nb);
    pc = 128'(c);
    if (sg && c[31]) pc = pc - (128'sd1 <<< 32);
    t = pa * pb;
    if (po) t = t + pc + 1;
    else if (nc) t = t - pc;
    else if (na ^ nb) t = pc - t;
    else t = t + pc;
    if (sc == 2'd1) t = t >>> 7;
    else if (sc == 2'd2) t = t >>> 15;
    if (st) begin
      hi = sg ? (128'sd1 <<< 31) - 1 : (128'sd1 <<< 32) - 1;
      lo = sg ? -(128'sd1 <<< 31) : 128'sd0;
      if (t > hi) t = hi;
      if (t < lo) t = lo;
    end
    return {2'b10, t[31:0]};
  endfunction

  task automatic drive(input logic [31:0] a, b, c, input logic [2:0] fa, fb,
      input logic [1:0] la, lb, input logic [3:0] ng, input logic [1:0] sc,
      input logic st);
    opa = a; opb = b; opc = c; fmt_a = fa; fmt_b = fb; lane_a = la; lane_b = lb;
    {neg_a, neg_b, neg_c, plus_one} = ng;
    scale = sc; saturate = st; in_valid = 1'b1;
  endtask

  task automatic run_one(input string tag, input logic [31:0] a, b, c,
      input logic [2:0] fa, fb, input logic [1:0] la, lb, input logic [3:0] ng,
      input logic [1:0] sc, input logic st);
    @(negedge clk);
    drive(a, b, c, fa, fb, la, lb, ng, sc, st);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check(tag, {out_valid, err, result},
          model(a, b, c, fa, fb, la, lb, ng[3], ng[2], ng[1], ng[0], sc, st));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  localparam logic [31:0] VA[4] = '{32'hFFFFFFFF, 32'h80000000, 32'h12345678, 32'h00807F01};
  localparam logic [31:0] VB[4] = '{32'hFFFFFFFF, 32'h7FFFFFFF, 32'h9ABCDEF0, 32'hFF8001FE};
  localparam logic [31:0] VC[4] = '{32'hFFFFFFFF, 32'h80000000, 32'h0F0F0F0F, 32'h7FFFFFFF};

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset", {out_valid, err, result}, 34'h0);
    rst_n = 1'b1;

    // R1: signed byte lane 3 of 0x80000000 times 1
    run_one("R1", 32'h80000000, 32'h1, 32'h0, 3'b100, 3'b000, 2'd3, 2'd0, 4'b0000, 2'd0, 1'b0);
    check("R1 value", {2'b10, result}, {2'b10, 32'hFFFFFF80});
    // R2: unsigned 1*1 minus 5 becomes signed; saturation keeps -4
    run_one("R2", 32'h1, 32'h1, 32'h5, 3'b010, 3'b010, 2'd0, 2'd0, 4'b0010, 2'd0, 1'b1);
    check("R2 value", {2'b10, result}, {2'b10, 32'hFFFFFFFC});
    // R4: both negations cancel (3*4+10=22), one negation gives 10-12
    run_one("R4", 32'h3, 32'h4, 32'hA, 3'b000, 3'b000, 2'd0, 2'd0, 4'b1100, 2'd0, 1'b0);
    check("R4 cancel", {2'b10, result}, {2'b10, 32'h00000016});
    run_one("R4", 32'h3, 32'h4, 32'hA, 3'b000, 3'b000, 2'd0, 2'd0, 4'b1000, 2'd0, 1'b0);
    check("R4 single", {2'b10, result}, {2'b10, 32'hFFFFFFFE});
    // R8: wrap without saturation, R7: clamp with it
    run_one("R8", 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 3'b010, 3'b010, 2'd0, 2'd0, 4'b0000, 2'd0, 1'b0);
    check("R8 value", {2'b10, result}, {2'b10, 32'h00000001});
    run_one("R7", 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 3'b010, 3'b010, 2'd0, 2'd0, 4'b0000, 2'd0, 1'b1);
    check("R7 value", {2'b10, result}, {2'b10, 32'hFFFFFFFF});

    // R9: back-to-back vectors, one result per cycle
    @(negedge clk);
    drive(32'd1, 32'd1, 32'd0, 3'b010, 3'b010, 2'd0, 2'd0, 4'b0000, 2'd0, 1'b0);
    @(negedge clk);
    opa = 32'd2;
    @(negedge clk);
    check("R9 first", {out_valid, err, result}, {2'b10, 32'd1});
    opa = 32'd3;
    @(negedge clk);
    check("R9 second", {out_valid, err, result}, {2'b10, 32'd2});
    in_valid = 1'b0;
    @(negedge clk);
    check("R9 third", {out_valid, err, result}, {2'b10, 32'd3});
    @(negedge clk);
    check("R9 idle", {out_valid, 33'h0}, 34'h0);

    // Sweep: R3 plain, R6 shifted, R7 saturated, R5 illegal
    for (int fa = 0; fa < 8; fa++)
      for (int fb = 0; fb < 8; fb++)
        for (int ng = 0; ng < 16; ng++)
          for (int sc = 0; sc < 4; sc++)
            for (int st = 0; st < 2; st++)
              for (int vi = 0; vi < 4; vi++) begin
                string tg;
                logic [33:0] e;
                e = model(VA[vi], VB[vi], VC[vi], 3'(fa), 3'(fb), 2'(vi), 2'(3 - vi),
                          ng[3], ng[2], ng[1], ng[0], 2'(sc), st[0]);
                tg = e[32] ? "R5" : (st != 0) ? "R7" : (sc != 0) ? "R6" : "R3";
                run_one(tg, VA[vi], VB[vi], VC[vi], 3'(fa), 3'(fb), 2'(vi), 2'(3 - vi),
                        4'(ng), 2'(sc), st[0]);
              end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule